// File: doc/BRIEF.md
# Two-Level Translation Walker with TLB

The block maps a 32-bit virtual address onto a physical address. It first looks in a small, fully associative translation cache. On a hit it answers in one cycle. On a miss it reads one or two descriptor words from a translation table held in memory, through a simple request/valid word-read port. It then answers with the physical address, the permission bits, the protection domain, the mapping size and a fault code.

Successful walks are written into the cache. The slot is chosen by a single pointer that moves round-robin. Software-side logic sets the table base through a write strobe. It can drop cached translations all at once, or only the ones that cover a given address.

Callers present a request while the block is not busy and read the result when the response strobe pulses. The result fields keep their value until the next response.

Top module: `vatrans_walker`

## Requirements
- R1: While reset is held and after its release: `busy`, `mem_req` and `rsp_valid` are low, `rsp_fault` is 0 (none), `rsp_domain` is 0 and `rsp_kind` is 0.
- R2: Bits [13:0] of the written table base are ignored. The first-level descriptor is read at `{base[31:14], va[31:20], 2'b00}`.
- R3: A first-level descriptor whose bits [1:0] are 2 maps a 1 MB section. The result is pa = `{desc[31:20], va[19:0]}`, perm = desc[11:0] & 0xC0C and kind = 3. A descriptor with type 0 or 3 returns fault code 1, with pa, perm and kind all 0.
- R4: A first-level descriptor with type 1 causes a second read at `{desc[31:10], va[19:12], 2'b00}`. In that second descriptor, type 2 is a 4 KB page: pa = `{d2[31:12], va[11:0]}`, kind 1. Type 1 is a 64 KB page: pa = `{d2[31:16], va[15:0]}`, kind 2. For both, perm = d2[11:0] & 0xFFC.
- R5: A second-level descriptor with type 0 or 3 returns fault code 2, with pa, perm and kind 0. A faulting walk is never cached, so repeating the address walks again.
- R6: `rsp_domain` takes first-level descriptor bits [8:5] after a successful walk or a page fault. On a hit it takes the cached domain. It keeps its previous value on a section fault.
- R7: The cache is searched before any memory access. A hit raises `rsp_valid` one cycle after acceptance, with no memory read. A miss raises `rsp_valid` one cycle after the last `mem_rvalid`.
- R8: The hit comparison keeps only the address bits above the page size of each entry: bits [31:20] for a section, [31:16] for a large page and [31:12] for a small page.
- R9: Each refill overwrites the slot at a round-robin pointer. The pointer starts at 0 after reset and advances modulo the entry count.
- R10: An address invalidate drops every valid entry whose tag matches the address under that entry's own page mask. Other entries keep hitting.
- R11: Invalidate-all drops every entry in one cycle.
- R12: `rsp_valid` is a one-cycle strobe. All result fields hold their values until the next response.
- R13: Once raised, `mem_req` and `mem_addr` stay unchanged until `mem_rvalid` is seen. `mem_req` is low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ttb_we | input | 1 | Table base write strobe |
| ttb_wdata | input | 32 | Table base value; bits [13:0] ignored |
| req_valid | input | 1 | Translation request; taken when idle and no invalidate is present |
| req_va | input | 32 | Virtual address to translate |
| inv_all | input | 1 | Invalidate all entries; acts only while idle |
| inv_addr_valid | input | 1 | Invalidate entries covering `inv_addr`; acts only while idle |
| inv_addr | input | 32 | Address for selective invalidate |
| busy | output | 1 | Table walk in progress |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor word |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_pa | output | 32 | Physical address |
| rsp_perm | output | 12 | Permission bits |
| rsp_domain | output | 4 | Domain of the latest walk or hit |
| rsp_kind | output | 2 | 0 none, 1 small page, 2 large page, 3 section |
| rsp_fault | output | 2 | 0 none, 1 section fault, 2 page fault |

## Verification
A corrupted cache entry or a mis-masked tag shows up at the ports either as a wrong physical address, or as a memory read where a hit was expected. Both are visible on the response to the very next request for that page. A pointer that advances wrongly only shows after a full round of refills: the next miss evicts the wrong victim. So the eviction order is probed right after the cache has been filled one entry past its capacity. A walker that decodes descriptors wrongly issues a read at an address outside the modelled table. That read returns zero and turns into an unexpected fault within the same request.

// File: rtl/vatrans_pkg.sv
package vatrans_pkg;

  typedef enum logic [1:0] {
    MAP_NONE    = 2'd0,
    MAP_SMALL   = 2'd1,
    MAP_LARGE   = 2'd2,
    MAP_SECTION = 2'd3
  } map_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_SECTION = 2'd1,
    FLT_PAGE    = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_L1   = 2'd1,
    WK_L2   = 2'd2
  } wk_state_e;

  // tags cover address bits [31:12]; coarser mappings store zeros below their size
  typedef struct packed {
    logic [19:0] vtag;
    logic [19:0] ptag;
    logic [11:0] perm;
    logic [3:0]  dom;
    map_kind_e   kind;
  } tlb_ent_t;

  function automatic logic [19:0] page_mask(map_kind_e k);
    case (k)
      MAP_SECTION: return 20'hFFF00;
      MAP_LARGE:   return 20'hFFFF0;
      default:     return 20'hFFFFF;
    endcase
  endfunction

  function automatic logic [31:0] form_pa(tlb_ent_t e, logic [31:0] va);
    logic [19:0] m;
    m = page_mask(e.kind);
    return {(e.ptag & m) | (va[31:12] & ~m), va[11:0]};
  endfunction

endpackage

// File: rtl/vatrans_tlb.sv
module vatrans_tlb
  import vatrans_pkg::*;
#(
  parameter int NUM_ENTRIES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [19:0] lk_tag,
  output logic        lk_hit,
  output tlb_ent_t    lk_ent,
  input  logic        fill_en,
  input  tlb_ent_t    fill_ent,
  input  logic        inv_all_en,
  input  logic        inv_addr_en,
  input  logic [19:0] inv_tag
);

  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [NUM_ENTRIES-1:0] vld_q, vld_d;
  logic [NUM_ENTRIES-1:0] lk_match, inv_match;
  tlb_ent_t               ent_q [NUM_ENTRIES];
  logic [IDX_W-1:0]       ptr_q, ptr_d;
  logic [IDX_W-1:0]       hit_idx;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    logic [19:0] msk;
    assign msk          = page_mask(ent_q[g].kind);
    assign lk_match[g]  = vld_q[g] && ((lk_tag  & msk) == ent_q[g].vtag);
    assign inv_match[g] = vld_q[g] && ((inv_tag & msk) == ent_q[g].vtag);
  end

  // lowest index wins when overlapping mappings both hit
  always_comb begin
    hit_idx = '0;
    lk_hit  = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i]) begin
        hit_idx = IDX_W'(i);
        lk_hit  = 1'b1;
      end
    end
  end

  assign lk_ent = ent_q[hit_idx];

  always_comb begin
    vld_d = vld_q;
    ptr_d = ptr_q;
    if (inv_all_en) begin
      vld_d = '0;
    end else if (inv_addr_en) begin
      vld_d = vld_q & ~inv_match;
    end
    if (fill_en) begin
      vld_d[ptr_q] = 1'b1;
      ptr_d = (ptr_q == IDX_W'(NUM_ENTRIES - 1)) ? '0 : ptr_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      ent_q[ptr_q] <= fill_ent;
    end
  end

endmodule

// File: rtl/vatrans_walk.sv
module vatrans_walk
  import vatrans_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_va,
  input  logic [17:0] ttb_base,
  output logic        busy,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output fault_e      done_fault,
  output logic        done_dom_upd,
  output tlb_ent_t    done_ent,
  output logic [31:0] done_va
);

  wk_state_e   st_q, st_d;
  logic [31:0] va_q, va_d;
  logic [31:0] addr_q, addr_d;
  logic [3:0]  dom_q, dom_d;

  always_comb begin
    st_d         = st_q;
    va_d         = va_q;
    addr_d       = addr_q;
    dom_d        = dom_q;
    done         = 1'b0;
    done_fault   = FLT_NONE;
    done_dom_upd = 1'b0;
    done_ent     = '0;
    unique case (st_q)
      WK_IDLE: begin
        if (start) begin
          st_d   = WK_L1;
          va_d   = start_va;
          addr_d = {ttb_base, start_va[31:20], 2'b00};
        end
      end
      WK_L1: begin
        if (mem_rvalid) begin
          unique case (mem_rdata[1:0])
            2'b10: begin
              st_d          = WK_IDLE;
              done          = 1'b1;
              done_dom_upd  = 1'b1;
              done_ent.vtag = {va_q[31:20], 8'h00};
              done_ent.ptag = {mem_rdata[31:20], 8'h00};
              done_ent.perm = mem_rdata[11:0] & 12'hC0C;
              done_ent.dom  = mem_rdata[8:5];
              done_ent.kind = MAP_SECTION;
            end
            2'b01: begin
              st_d   = WK_L2;
              addr_d = {mem_rdata[31:10], va_q[19:12], 2'b00};
              dom_d  = mem_rdata[8:5];
            end
            default: begin
              st_d       = WK_IDLE;
              done       = 1'b1;
              done_fault = FLT_SECTION;
            end
          endcase
        end
      end
      WK_L2: begin
        if (mem_rvalid) begin
          st_d         = WK_IDLE;
          done         = 1'b1;
          done_dom_upd = 1'b1;
          done_ent.dom = dom_q;
          unique case (mem_rdata[1:0])
            2'b10: begin
              done_ent.vtag = va_q[31:12];
              done_ent.ptag = mem_rdata[31:12];
              done_ent.perm = mem_rdata[11:0] & 12'hFFC;
              done_ent.kind = MAP_SMALL;
            end
            2'b01: begin
              done_ent.vtag = {va_q[31:16], 4'h0};
              done_ent.ptag = {mem_rdata[31:16], 4'h0};
              done_ent.perm = mem_rdata[11:0] & 12'hFFC;
              done_ent.kind = MAP_LARGE;
            end
            default: begin
              done_fault = FLT_PAGE;
            end
          endcase
        end
      end
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= WK_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk) begin
    va_q   <= va_d;
    addr_q <= addr_d;
    dom_q  <= dom_d;
  end

  assign busy     = (st_q != WK_IDLE);
  assign mem_req  = busy;
  assign mem_addr = addr_q;
  assign done_va  = va_q;

endmodule

// File: rtl/vatrans_walker.sv
module vatrans_walker
  import vatrans_pkg::*;
#(
  parameter int NUM_ENTRIES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ttb_we,
  input  logic [31:0] ttb_wdata,
  input  logic        req_valid,
  input  logic [31:0] req_va,
  input  logic        inv_all,
  input  logic        inv_addr_valid,
  input  logic [31:0] inv_addr,
  output logic        busy,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_pa,
  output logic [11:0] rsp_perm,
  output logic [3:0]  rsp_domain,
  output logic [1:0]  rsp_kind,
  output logic [1:0]  rsp_fault
);

  logic [17:0] ttb_q;
  logic        unused_ttb_lo;
  logic        accept, hit_acc, miss_acc, inv_ok;
  logic        lk_hit;
  tlb_ent_t    lk_ent;
  logic        wk_done, wk_dom_upd, fill_en;
  fault_e      wk_fault;
  tlb_ent_t    wk_ent, sel_ent;
  logic [31:0] wk_va, sel_va;

  logic        vld_q, vld_d;
  logic [31:0] pa_q, pa_d;
  logic [11:0] perm_q, perm_d;
  logic [3:0]  dom_q, dom_d;
  map_kind_e   kind_q, kind_d;
  fault_e      flt_q, flt_d;

  assign unused_ttb_lo = ^ttb_wdata[13:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ttb_q <= '0;
    end else if (ttb_we) begin
      ttb_q <= ttb_wdata[31:14];
    end
  end

  assign inv_ok   = !busy;
  assign accept   = req_valid && !busy && !inv_all && !inv_addr_valid;
  assign hit_acc  = accept && lk_hit;
  assign miss_acc = accept && !lk_hit;
  assign fill_en  = wk_done && (wk_fault == FLT_NONE);

  vatrans_tlb #(
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_tlb (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_tag     (req_va[31:12]),
    .lk_hit     (lk_hit),
    .lk_ent     (lk_ent),
    .fill_en    (fill_en),
    .fill_ent   (wk_ent),
    .inv_all_en (inv_all && inv_ok),
    .inv_addr_en(inv_addr_valid && inv_ok),
    .inv_tag    (inv_addr[31:12])
  );

  vatrans_walk u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (miss_acc),
    .start_va    (req_va),
    .ttb_base    (ttb_q),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .done        (wk_done),
    .done_fault  (wk_fault),
    .done_dom_upd(wk_dom_upd),
    .done_ent    (wk_ent),
    .done_va     (wk_va)
  );

  always_comb begin
    sel_ent = wk_done ? wk_ent : lk_ent;
    sel_va  = wk_done ? wk_va  : req_va;
    vld_d   = hit_acc || wk_done;
    pa_d    = pa_q;
    perm_d  = perm_q;
    dom_d   = dom_q;
    kind_d  = kind_q;
    flt_d   = flt_q;
    if (hit_acc || wk_done) begin
      flt_d = wk_done ? wk_fault : FLT_NONE;
      if (flt_d == FLT_NONE) begin
        pa_d   = form_pa(sel_ent, sel_va);
        perm_d = sel_ent.perm;
        kind_d = sel_ent.kind;
      end else begin
        pa_d   = '0;
        perm_d = '0;
        kind_d = MAP_NONE;
      end
      if (hit_acc || wk_dom_upd) begin
        dom_d = sel_ent.dom;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      pa_q   <= '0;
      perm_q <= '0;
      dom_q  <= '0;
      kind_q <= MAP_NONE;
      flt_q  <= FLT_NONE;
    end else begin
      vld_q  <= vld_d;
      pa_q   <= pa_d;
      perm_q <= perm_d;
      dom_q  <= dom_d;
      kind_q <= kind_d;
      flt_q  <= flt_d;
    end
  end

  assign rsp_valid  = vld_q;
  assign rsp_pa     = pa_q;
  assign rsp_perm   = perm_q;
  assign rsp_domain = dom_q;
  assign rsp_kind   = kind_q;
  assign rsp_fault  = flt_q;

endmodule

// File: rtl/vatrans_walker_chk.sv
module vatrans_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        inv_all,
  input logic        inv_addr_valid,
  input logic        busy,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        rsp_valid,
  input logic [31:0] rsp_pa,
  input logic [11:0] rsp_perm,
  input logic [1:0]  rsp_kind,
  input logic [1:0]  rsp_fault
);

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R13

  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R13

  AST_WALK_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(req_valid && !busy && !inv_all && !inv_addr_valid)); // R7

  AST_WALK_ENDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid); // R7

  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != 2'd0) |-> (rsp_kind == 2'd0 && rsp_pa == 32'h0 && rsp_perm == 12'h0)); // R5

  AST_SECTION_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_kind == 2'd3) |-> ((rsp_perm & ~12'hC0C) == 12'h0)); // R3

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ($stable(rsp_fault) && $stable(rsp_pa) && $stable(rsp_kind))); // R12

endmodule

bind vatrans_walker vatrans_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .inv_all       (inv_all),
  .inv_addr_valid(inv_addr_valid),
  .busy          (busy),
  .mem_req       (mem_req),
  .mem_addr      (mem_addr),
  .mem_rvalid    (mem_rvalid),
  .rsp_valid     (rsp_valid),
  .rsp_pa        (rsp_pa),
  .rsp_perm      (rsp_perm),
  .rsp_kind      (rsp_kind),
  .rsp_fault     (rsp_fault)
);

// File: tb/vatrans_walker_bench.sv
module vatrans_walker_bench;

  localparam int TB_N    = 32;
  localparam int MEM_LAT = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ttb_we = 1'b0;
  logic [31:0] ttb_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        inv_all = 1'b0;
  logic        inv_addr_valid = 1'b0;
  logic [31:0] inv_addr = '0;
  logic        busy, mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_pa;
  logic [11:0] rsp_perm;
  logic [3:0]  rsp_domain;
  logic [1:0]  rsp_kind, rsp_fault;

  int n_tests = 0;
  int n_fail  = 0;
  int rd_count = 0;
  int lat_cnt = 0;
  int addr_moves = 0;
  logic [31:0] hold_addr = '0;
  logic [31:0] first_addr = '0;
  int walked, waits;

  logic [31:0] mem_map [logic [31:0]];

  always #5 clk = ~clk;

  vatrans_walker #(.NUM_ENTRIES(TB_N)) u_vatrans_walker (
    .clk(clk), .rst_n(rst_n), .ttb_we(ttb_we), .ttb_wdata(ttb_wdata),
    .req_valid(req_valid), .req_va(req_va), .inv_all(inv_all),
    .inv_addr_valid(inv_addr_valid), .inv_addr(inv_addr), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
    .rsp_perm(rsp_perm), .rsp_domain(rsp_domain), .rsp_kind(rsp_kind),
    .rsp_fault(rsp_fault)
  );

  function automatic logic [31:0] mem_read(logic [31:0] a);
    if (mem_map.exists(a)) return mem_map[a];
    return 32'h0;
  endfunction

  // memory model: answers each request after MEM_LAT extra cycles
  always @(negedge clk) begin
    if (mem_rvalid) begin
      mem_rvalid <= 1'b0;
    end else if (mem_req) begin
      if (lat_cnt == 0) hold_addr <= mem_addr;
      else if (mem_addr != hold_addr) addr_moves <= addr_moves + 1;
      if (lat_cnt == MEM_LAT) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_read(mem_addr);
        lat_cnt    <= 0;
        rd_count   <= rd_count + 1;
        if (rd_count == 0) first_addr <= mem_addr;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] va);
    int start_rd;
    start_rd = rd_count;
    waits = 0;
    req_va = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) begin
      @(negedge clk);
      waits++;
    end
    walked = rd_count - start_rd;
  endtask

  task automatic write_ttb(input logic [31:0] v);
    ttb_wdata = v;
    ttb_we = 1'b1;
    @(negedge clk);
    ttb_we = 1'b0;
  endtask

  task automatic inv_one(input logic [31:0] a);
    inv_addr = a;
    inv_addr_valid = 1'b1;
    @(negedge clk);
    inv_addr_valid = 1'b0;
  endtask

  task automatic inv_every();
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
  endtask

  // va, pa, perm, domain, fault, kind, memory reads
  localparam int NV = 13;
  localparam logic [85:0] VEC [NV] = '{
    {32'h12345678, 32'h8AB45678, 12'h808, 4'h5, 2'd0, 2'd3, 2'd1}, // R3 section walk
    {32'h123FFFFC, 32'h8ABFFFFC, 12'h808, 4'h5, 2'd0, 2'd3, 2'd0}, // R8 section hit
    {32'h00403ABC, 32'h76543ABC, 12'hAB4, 4'h9, 2'd0, 2'd1, 2'd2}, // R4 small walk
    {32'h00403000, 32'h76543000, 12'hAB4, 4'h9, 2'd0, 2'd1, 2'd0}, // R8 small hit
    {32'h00456789, 32'h9ABC6789, 12'h55C, 4'h9, 2'd0, 2'd2, 2'd2}, // R4 large walk
    {32'h00450010, 32'h9ABC0010, 12'h55C, 4'h9, 2'd0, 2'd2, 2'd0}, // R8 large hit
    {32'h00501000, 32'h00000000, 12'h000, 4'hC, 2'd2, 2'd0, 2'd2}, // R5 page fault type 0
    {32'h00501000, 32'h00000000, 12'h000, 4'hC, 2'd2, 2'd0, 2'd2}, // R5 not cached
    {32'h00502000, 32'h00000000, 12'h000, 4'hC, 2'd2, 2'd0, 2'd2}, // R5 page fault type 3
    {32'h0FF00000, 32'h00000000, 12'h000, 4'hC, 2'd1, 2'd0, 2'd1}, // R3 type 0, R6 domain held
    {32'h0FE00000, 32'h00000000, 12'h000, 4'hC, 2'd1, 2'd0, 2'd1}, // R3 type 3
    {32'h12300004, 32'h8AB00004, 12'h808, 4'h5, 2'd0, 2'd3, 2'd0}, // R6 hit domain
    {32'h0FF00000, 32'h00000000, 12'h000, 4'h5, 2'd1, 2'd0, 2'd1}  // R6 held after hit
  };

  initial begin
    logic [85:0] v;
    logic [31:0] e_va, e_pa;
    logic [11:0] e_perm;
    logic [3:0]  e_dom;
    logic [1:0]  e_flt, e_kind, e_rd;

    mem_map[32'h0000448C] = 32'h8AB008BA;
    mem_map[32'h00004010] = 32'h00020521;
    mem_map[32'h0002040C] = 32'h76543AB6;
    mem_map[32'h00020558] = 32'h9ABC055D;
    mem_map[32'h00004014] = 32'h00030181;
    mem_map[32'h00030008] = 32'h00000003;
    mem_map[32'h000043F8] = 32'hFFFFFFFF;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 busy in reset", {31'h0, busy}, 32'h0);
    check("R1 mem_req in reset", {31'h0, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check("R1 fault/kind/domain", {24'h0, rsp_fault, rsp_kind, rsp_domain}, 32'h0);

    write_ttb(32'h00007FFF); // R2 low bits dropped

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      e_va = v[85:54]; e_pa = v[53:22]; e_perm = v[21:10];
      e_dom = v[9:6]; e_flt = v[5:4]; e_kind = v[3:2]; e_rd = v[1:0];
      xlate(e_va);
      check((e_flt != 0) ? "R5/R3 fault code" : "R3/R4 fault code", {30'h0, rsp_fault}, {30'h0, e_flt});
      check((e_kind == 3) ? "R3 pa" : "R4 pa", rsp_pa, e_pa);
      check("R3/R4 perm", {20'h0, rsp_perm}, {20'h0, e_perm});
      check("R3/R4 kind", {30'h0, rsp_kind}, {30'h0, e_kind});
      check("R6 domain", {28'h0, rsp_domain}, {28'h0, e_dom});
      check("R7 memory reads", walked, {30'h0, e_rd});
      if (e_rd == 0) check("R7 hit latency", waits, 0);
      if (i == 0) check("R2 first descriptor address", first_addr, 32'h0000448C);
    end

    // R12 hold
    @(negedge clk);
    check("R12 strobe one cycle", {31'h0, rsp_valid}, 32'h0);
    repeat (4) @(negedge clk);
    check("R12 fault held", {30'h0, rsp_fault}, 32'd1);
    check("R12 domain held", {28'h0, rsp_domain}, 32'h5);

    // R10 selective invalidate
    inv_one(32'h00403FFF);
    xlate(32'h00456789);
    check("R10 large entry kept", walked, 0);
    check("R10 large pa", rsp_pa, 32'h9ABC6789);
    xlate(32'h00403ABC);
    check("R10 small entry dropped", walked, 2);
    check("R10 small pa", rsp_pa, 32'h76543ABC);
    inv_one(32'h12380000);
    xlate(32'h12345678);
    check("R10 section dropped by masked match", walked, 1);

    // R11 invalidate all
    inv_every();
    xlate(32'h00456789);
    check("R11 large walked again", walked, 2);
    xlate(32'h00403ABC);
    check("R11 small walked again", walked, 2);
    check("R13 address stable while waiting", addr_moves, 0);

    // R9 round robin after fresh reset
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    write_ttb(32'h00004000);
    for (int k = 0; k <= TB_N; k++) begin
      mem_map[32'h00004000 + (32'h200 + k) * 4] = ((32'h300 + k) << 20) | 32'h2;
    end
    for (int k = 0; k <= TB_N; k++) begin
      xlate((32'h200 + k) << 20);
      check("R9 fill walk", walked, 1);
    end
    xlate(32'h201 << 20);
    check("R9 second slot survives", walked, 0);
    xlate(32'h200 << 20);
    check("R9 oldest evicted", walked, 1);
    check("R9 pa after refill", rsp_pa, 32'h30000000);
    xlate(32'h202 << 20);
    check("R9 third slot survives", walked, 0);
    xlate(32'h201 << 20);
    check("R9 pointer moved to slot 1", walked, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule